// File: doc/BRIEF.md
# External Interrupt Request Capture

This block turns active-low external interrupt pins into interrupt request flags that an interrupt controller can read. Each line has its own type-select input. In level mode the flag follows the pin. In falling-edge mode the flag is captured on a high-to-low transition and held until the controller accepts it.

The pin is asynchronous. It passes through a synchronizer chain before any decision is made on it. Software can write each flag directly. Writing 1 produces a request that looks the same as one raised by the pin. Writing 0 cancels a pending edge request.

The number of lines is a parameter, and the default of two covers a pair of external pins. Arbitration between sources and vector selection belong to the controller that reads the flags.

Top module: `ext_irq_capture`

## Requirements
- R1: While `rst_n` is low, every bit of `req` is 0. After release, `req` stays 0 until a pin event or a software write occurs.
- R2: With `trig_edge[i]`=1 (falling-edge mode), a high-to-low change on `pin_n[i]` sets `req[i]` to 1 at the third rising clock edge after the change. The flag then stays 1 after the pin returns high.
- R3: In falling-edge mode, a one-cycle `accept[i]` pulse clears `req[i]` at the next rising edge.
- R4: With `trig_edge[i]`=0 (level mode), `req[i]` equals the inverse of `pin_n[i]`. The latency is the same three edges as in R2.
- R5: In level mode, `accept[i]` has no effect. The request stays 1 for as long as the pin is low, so a line that is still low after service requests again immediately.
- R6: `sw_we[i]`=1 loads `sw_wdata[i]` into `req[i]` at the next edge. In edge mode the written value is held. In level mode, tracking of the pin resumes one cycle later.
- R7: In edge mode, if a falling edge is detected in the same cycle as `accept[i]`, the flag stays 1, so the new edge is not lost.
- R8: In edge mode, a pin held low or a low-to-high change never sets the flag.
- R9: A software write takes precedence over a falling edge and over an acceptance in the same cycle.
- R10: The lines are independent. Activity on one line never changes the flag of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NUM_LINES | Asynchronous active-low interrupt pins |
| trig_edge | input | NUM_LINES | Per-line type select: 0 selects level, 1 selects falling edge |
| accept | input | NUM_LINES | One-cycle acceptance pulse from the controller |
| sw_we | input | NUM_LINES | Software write strobe for the flag |
| sw_wdata | input | NUM_LINES | Value that software writes to the flag |
| req | output | NUM_LINES | Interrupt request flags |

## Verification
The hardest case to reach from the ports is an acceptance that lands in exactly the cycle the falling edge is detected. The edge is only visible inside the synchronizer for one cycle. The stimulus therefore drops the pin, waits exactly two rising edges, and then pulses `accept` for one cycle, so that both events meet at the third edge. A software write of 0 is timed the same way to check the precedence rule. A behavioural reference model, built on a per-line sample history, is compared with `req` on every clock.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;
   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_FALL  = 1'b1
   } trig_mode_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_sync
);
   // The chain resets to the idle (high) pin level so release makes no false edge.
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], pin_async};
   end

   assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_fall_detect.sv
module irq_fall_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level_in;
   end

   assign fall = prev_q & ~level_in;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
   import irq_capture_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  trig_mode_e mode,
   input  logic       pin_level,
   input  logic       fall,
   input  logic       accept,
   input  logic       sw_we,
   input  logic       sw_wdata,
   output logic       flag
);
   logic flag_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (sw_we) begin
         flag_d = sw_wdata;
      end else if (mode == TRIG_LEVEL) begin
         flag_d = ~pin_level;
      end else if (fall) begin
         flag_d = 1'b1;            // a new edge beats a coincident accept
      end else if (accept) begin
         flag_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
   import irq_capture_pkg::*;
#(
   parameter int NUM_LINES   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_n,
   input  logic [NUM_LINES-1:0] trig_edge,
   input  logic [NUM_LINES-1:0] accept,
   input  logic [NUM_LINES-1:0] sw_we,
   input  logic [NUM_LINES-1:0] sw_wdata,
   output logic [NUM_LINES-1:0] req
);
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("ext_irq_capture: NUM_LINES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_capture: SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] pin_s;
   logic [NUM_LINES-1:0] fall_det;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_async (pin_n[i]),
         .pin_sync  (pin_s[i])
      );

      irq_fall_detect u_fall (
         .clk      (clk),
         .rst_n    (rst_n),
         .level_in (pin_s[i]),
         .fall     (fall_det[i])
      );

      irq_flag_cell u_flag (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode      (trig_mode_e'(trig_edge[i])),
         .pin_level (pin_s[i]),
         .fall      (fall_det[i]),
         .accept    (accept[i]),
         .sw_we     (sw_we[i]),
         .sw_wdata  (sw_wdata[i]),
         .flag      (req[i])
      );
   end
endmodule

// File: rtl/irq_capture_checker.sv
module irq_capture_checker #(
   parameter int NUM_LINES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] trig_edge,
   input logic [NUM_LINES-1:0] accept,
   input logic [NUM_LINES-1:0] sw_we,
   input logic [NUM_LINES-1:0] sw_wdata,
   input logic [NUM_LINES-1:0] pin_s,
   input logic [NUM_LINES-1:0] fall_det,
   input logic [NUM_LINES-1:0] req
);
   assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |-> (req == '0));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_edge[i] && fall_det[i] && !sw_we[i]) |=> req[i]);

      assert_accept_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_edge[i] && accept[i] && !fall_det[i] && !sw_we[i]) |=> !req[i]);

      // R5: level mode ignores accept, so the flag simply tracks the pin
      assert_level_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig_edge[i] && !sw_we[i]) |=> (req[i] == !$past(pin_s[i])));

      assert_sw_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         sw_we[i] |=> (req[i] == $past(sw_wdata[i])));

      assert_edge_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_edge[i] && !fall_det[i] && !accept[i] && !sw_we[i]) |=> $stable(req[i]));
   end
endmodule

bind ext_irq_capture irq_capture_checker #(.NUM_LINES(NUM_LINES)) u_irq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_edge (trig_edge),
   .accept    (accept),
   .sw_we     (sw_we),
   .sw_wdata  (sw_wdata),
   .pin_s     (pin_s),
   .fall_det  (fall_det),
   .req       (req)
);

// File: tb/ext_irq_capture_bench.sv
module ext_irq_capture_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic [NL-1:0] pin_n, trig_edge, accept, sw_we, sw_wdata, req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string phase = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_irq_capture #(.NUM_LINES(NL), .SYNC_STAGES(2)) u_ext_irq_capture (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .trig_edge(trig_edge),
      .accept(accept), .sw_we(sw_we), .sw_wdata(sw_wdata), .req(req)
   );

   // Reference model: per-line history of pin samples, newest in bit 0.
   logic [2:0] hist [NL];
   bit         mflag [NL];

   always @(posedge clk or negedge rst_n) begin
      bit fall;
      if (!rst_n) begin
         for (int i = 0; i < NL; i++) begin
            hist[i] = 3'b111;
            mflag[i] = 1'b0;
         end
      end else begin
         for (int i = 0; i < NL; i++) begin
            fall = hist[i][2] & ~hist[i][1];
            if (sw_we[i])          mflag[i] = sw_wdata[i];
            else if (!trig_edge[i]) mflag[i] = ~hist[i][1];
            else if (fall)         mflag[i] = 1'b1;
            else if (accept[i])    mflag[i] = 1'b0;
            hist[i] = {hist[i][1:0], pin_n[i]};
         end
      end
   end

   task automatic chk(string tag, int line, logic exp);
      checks++;
      if (req[line] !== exp) begin
         failures++;
         $display("FAIL %s line %0d: req=%b expected=%b at %0t", tag, line, req[line], exp, $time);
      end
   endtask

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         for (int i = 0; i < NL; i++) chk({phase, " model"}, i, mflag[i]);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      pin_n = '1; trig_edge = 2'b01; accept = '0; sw_we = '0; sw_wdata = '0;
      step(3);
      chk("R1 during reset", 0, 1'b0);
      chk("R1 during reset", 1, 1'b0);
      rst_n = 1'b1;
      step(4);
      chk("R1 after release", 0, 1'b0);
      chk("R1 after release", 1, 1'b0);

      // R2: falling edge on line 0 (edge mode), three-edge latency
      phase = "R2";
      pin_n[0] = 1'b0;
      step(2);
      chk("R2 not yet", 0, 1'b0);
      step(1);
      chk("R2 edge sets", 0, 1'b1);
      pin_n[0] = 1'b1;
      step(4);
      chk("R2 held after rise", 0, 1'b1);
      chk("R10 other line idle", 1, 1'b0);

      // R3: acceptance clears
      phase = "R3";
      accept[0] = 1'b1; step(1); accept[0] = 1'b0;
      chk("R3 accept clears", 0, 1'b0);

      // R8: steady low and rising edge do not set
      phase = "R8";
      pin_n[0] = 1'b0; step(3);
      chk("R8 setup edge", 0, 1'b1);
      accept[0] = 1'b1; step(1); accept[0] = 1'b0;
      step(5);
      chk("R8 steady low", 0, 1'b0);
      pin_n[0] = 1'b1; step(5);
      chk("R8 rising edge", 0, 1'b0);

      // R7: edge detected in the same cycle as accept
      phase = "R7";
      pin_n[0] = 1'b0; step(2);
      accept[0] = 1'b1; step(1); accept[0] = 1'b0;
      chk("R7 edge with accept", 0, 1'b1);
      accept[0] = 1'b1; step(1); accept[0] = 1'b0;
      chk("R7 later accept clears", 0, 1'b0);
      pin_n[0] = 1'b1; step(4);

      // R9: software write of 0 coincides with a detected edge
      phase = "R9";
      pin_n[0] = 1'b0; step(2);
      sw_we[0] = 1'b1; sw_wdata[0] = 1'b0; step(1); sw_we[0] = 1'b0;
      chk("R9 write beats edge", 0, 1'b0);
      step(3);
      chk("R9 edge consumed", 0, 1'b0);
      pin_n[0] = 1'b1; step(4);

      // R6: software set and cancel in edge mode
      phase = "R6";
      sw_we[0] = 1'b1; sw_wdata[0] = 1'b1; step(1); sw_we[0] = 1'b0;
      chk("R6 write 1", 0, 1'b1);
      step(3);
      chk("R6 write held", 0, 1'b1);
      sw_we[0] = 1'b1; sw_wdata[0] = 1'b0; step(1); sw_we[0] = 1'b0;
      chk("R6 write 0 cancels", 0, 1'b0);
      // R9: write 1 beats a coincident accept
      sw_we[0] = 1'b1; sw_wdata[0] = 1'b1; accept[0] = 1'b1; step(1);
      sw_we[0] = 1'b0; accept[0] = 1'b0;
      chk("R9 write beats accept", 0, 1'b1);

      // R4/R5: level mode on line 1
      phase = "R4";
      pin_n[1] = 1'b0; step(2);
      chk("R4 latency", 1, 1'b0);
      step(1);
      chk("R4 low asserts", 1, 1'b1);
      chk("R10 line 0 untouched", 0, 1'b1);
      phase = "R5";
      accept[1] = 1'b1; step(4); accept[1] = 1'b0;
      chk("R5 accept ignored", 1, 1'b1);
      phase = "R4";
      pin_n[1] = 1'b1; step(3);
      chk("R4 high deasserts", 1, 1'b0);
      // R6: level-mode write lasts one cycle
      phase = "R6";
      sw_we[1] = 1'b1; sw_wdata[1] = 1'b1; step(1); sw_we[1] = 1'b0;
      chk("R6 level write", 1, 1'b1);
      step(1);
      chk("R6 level tracking resumes", 1, 1'b0);

      // R10: both lines active with different patterns
      phase = "R10";
      trig_edge = 2'b11;
      pin_n = 2'b00; step(3);
      chk("R10 both edges", 0, 1'b1);
      chk("R10 both edges", 1, 1'b1);
      accept = 2'b10; step(1); accept = '0;
      chk("R10 accept line 1 only", 0, 1'b1);
      chk("R10 accept line 1 only", 1, 1'b0);
      pin_n = '1; step(4);

      finish_run();
   end
endmodule